// File: doc/BRIEF.md
# Loop-Body Coprocessor with Split Memory and Datapath Timing

This block runs one fixed loop as a single call. For every index `i` from 0 up to `N-1` it fetches `x` from array A at `i` and `y` from array B at `i`. It then fetches `D[y]` and writes `C[x] = D[y] + x + y + x*y`. The caller starts the block with a one-cycle pulse that carries the four array base addresses and the trip count. The block raises `done` when the loop has finished and holds it there.

Two timing regimes coexist inside the block. The memory side runs on the fast clock. A small sequencer issues the four accesses of an iteration through one multiplexed request port, strictly in program order, and the returned load values land in fast-clock operand registers. The whole loop-body arithmetic is one unregistered path from those operands to the store data and the next loop index. The loop index is the only value that crosses from one iteration to the next. It updates only on a one-cycle commit pulse, which fires when the block's final memory operation completes. That pulse acts as a slow, aperiodic datapath clock enable and is brought out as `blk_commit`.

Memory is an external synchronous port with a fixed two-cycle response latency. A response is returned for stores as well as loads. All addresses are word addresses that wrap modulo 2^AW, and data arithmetic wraps modulo 2^DW.

Top module: `loop_coproc`

## Requirements
- R1: While reset is asserted and after it is released, `done`, `mem_req` and `blk_commit` are low until a start is accepted.
- R2: A start is accepted when the block is idle or finished. For N ≥ 1, `done` rises exactly 12·N+1 cycles after the start edge, which is one cycle after the final `blk_commit`. `done` then stays high with no further requests until the next start.
- R3: A start with N = 0 raises `done` in the next cycle, and no memory request is issued.
- R4: Each iteration issues four requests in this order: load at base_a+i, load at base_b+i, load at base_d+y, then store at base_c+x. All address arithmetic is modulo 2^AW.
- R5: Only one request is outstanding at a time. Each request lasts one cycle, its response arrives two cycles later, and the next request is issued in the cycle after that response, so requests are 3 cycles apart. `mem_we` is 1 only for the store.
- R6: The store data equals D[y] + x + y + x·y modulo 2^DW, computed from the values loaded in the same iteration.
- R7: `blk_commit` is a one-cycle pulse, once per iteration, in the cycle in which the store's response arrives. The loop index changes only on that pulse or when a start is accepted.
- R8: The loop continues while i+1 < N, so a call makes exactly 4·N requests.
- R9: Program order holds even when the C and D regions overlap. A later iteration's load of D sees every earlier store, so the final memory matches a sequential execution of the loop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Call pulse; arguments sampled with it |
| base_a | input | AW | Base word address of array A |
| base_b | input | AW | Base word address of array B |
| base_c | input | AW | Base word address of array C |
| base_d | input | AW | Base word address of array D |
| count_n | input | CW | Trip count N |
| done | output | 1 | Call finished; held until next start |
| blk_commit | output | 1 | Slow datapath enable, one pulse per iteration |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a store |
| mem_addr | output | AW | Request word address |
| mem_wdata | output | DW | Store data |
| mem_rvalid | input | 1 | Response valid, two cycles after request |
| mem_rdata | input | DW | Load data |

## Verification
The assertions check on every cycle that only one request is ever outstanding, that requests are spaced by the response latency, and that the commit pulse is one cycle wide and coincides with a response. They also check that the loop index moves only on a commit or an accepted start, and that `done` rises only after a commit or a zero-count start and then holds with the port quiet. The address order, the store values, the exact call latency and the sequential semantics with overlapping arrays can only be shown by the bench. It sweeps trip counts 0 to 7 across data patterns, wrapped base addresses and overlapping C/D regions. It compares every logged request and the final memory image against a reference loop.

// File: rtl/lc_pkg.sv
package lc_pkg;
  typedef enum logic [1:0] {
    OP_LDA = 2'd0,
    OP_LDB = 2'd1,
    OP_LDD = 2'd2,
    OP_STC = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/lc_rst_sync.sv
module lc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/lc_body_op.sv
// Whole loop body as one combinational operator: no registers inside.
module lc_body_op #(
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic [DW-1:0] x_val,
  input  logic [DW-1:0] y_val,
  input  logic [DW-1:0] d_val,
  input  logic [CW-1:0] idx,
  input  logic [CW-1:0] trip,
  output logic [DW-1:0] result,
  output logic [CW-1:0] idx_next,
  output logic          more
);
  always_comb begin
    result   = d_val + x_val + y_val + (x_val * y_val);
    idx_next = idx + CW'(1);
    more     = ({1'b0, idx} + (CW+1)'(1)) < {1'b0, trip};
  end
endmodule

// File: rtl/lc_mem_mux.sv
// Selects address, write enable and data of the single memory port by op.
module lc_mem_mux
  import lc_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  op_e           op,
  input  logic          issue,
  input  logic [AW-1:0] arg_a,
  input  logic [AW-1:0] arg_b,
  input  logic [AW-1:0] arg_c,
  input  logic [AW-1:0] arg_d,
  input  logic [CW-1:0] idx,
  input  logic [DW-1:0] x_val,
  input  logic [DW-1:0] y_val,
  input  logic [DW-1:0] result,
  output logic [AW-1:0] addr,
  output logic          we,
  output logic [DW-1:0] wdata
);
  logic [AW-1:0] idx_a;
  logic [AW-1:0] x_a;
  logic [AW-1:0] y_a;

  always_comb begin
    idx_a = AW'(idx);
    x_a   = AW'(x_val);
    y_a   = AW'(y_val);
    wdata = '0;
    we    = 1'b0;
    unique case (op)
      OP_LDA: addr = arg_a + idx_a;
      OP_LDB: addr = arg_b + idx_a;
      OP_LDD: addr = arg_d + y_a;
      OP_STC: begin
        addr  = arg_c + x_a;
        we    = issue;
        wdata = result;
      end
      default: addr = '0;
    endcase
  end
endmodule

// File: rtl/lc_block_seq.sv
// Fast-clock sequencer: issues the memory ops of one block in program order.
module lc_block_seq
  import lc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic n_is_zero,
  input  logic rsp_valid,
  input  logic more,
  output logic accept,
  output logic req,
  output op_e  op,
  output logic cap_x,
  output logic cap_y,
  output logic cap_d,
  output logic commit,
  output logic done
);
  seq_state_e state_q, state_d;
  op_e        op_q, op_d;
  logic       rsp_here;

  always_comb begin
    state_d  = state_q;
    op_d     = op_q;
    accept   = 1'b0;
    rsp_here = (state_q == ST_WAIT) && rsp_valid;
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          accept  = 1'b1;
          op_d    = OP_LDA;
          state_d = n_is_zero ? ST_DONE : ST_ISSUE;
        end
      end
      ST_ISSUE: state_d = ST_WAIT;
      ST_WAIT: begin
        if (rsp_valid) begin
          if (op_q == OP_STC) begin
            op_d    = OP_LDA;
            state_d = more ? ST_ISSUE : ST_DONE;
          end else begin
            op_d    = op_e'(op_q + 2'd1);
            state_d = ST_ISSUE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= OP_LDA;
    end else begin
      state_q <= state_d;
      op_q    <= op_d;
    end
  end

  assign req    = (state_q == ST_ISSUE);
  assign op     = op_q;
  assign cap_x  = rsp_here && (op_q == OP_LDA);
  assign cap_y  = rsp_here && (op_q == OP_LDB);
  assign cap_d  = rsp_here && (op_q == OP_LDD);
  assign commit = rsp_here && (op_q == OP_STC);
  assign done   = (state_q == ST_DONE);
endmodule

// File: rtl/loop_coproc.sv
module loop_coproc
  import lc_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] base_a,
  input  logic [AW-1:0] base_b,
  input  logic [AW-1:0] base_c,
  input  logic [AW-1:0] base_d,
  input  logic [CW-1:0] count_n,
  output logic          done,
  output logic          blk_commit,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata
);
  logic          rst_i_n;
  logic          accept;
  logic          cap_x, cap_y, cap_d;
  logic          more;
  op_e           op;
  logic [AW-1:0] arg_a_q, arg_b_q, arg_c_q, arg_d_q;
  logic [CW-1:0] trip_q;
  logic [DW-1:0] x_q, y_q, d_q;
  logic [DW-1:0] result;
  logic [CW-1:0] idx_q, idx_d, idx_next;

  lc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  lc_block_seq u_seq (
    .clk(clk), .rst_n(rst_i_n), .start(start),
    .n_is_zero(count_n == '0), .rsp_valid(mem_rvalid), .more(more),
    .accept(accept), .req(mem_req), .op(op),
    .cap_x(cap_x), .cap_y(cap_y), .cap_d(cap_d),
    .commit(blk_commit), .done(done)
  );

  lc_body_op #(.DW(DW), .CW(CW)) u_body (
    .x_val(x_q), .y_val(y_q), .d_val(d_q), .idx(idx_q), .trip(trip_q),
    .result(result), .idx_next(idx_next), .more(more)
  );

  lc_mem_mux #(.AW(AW), .DW(DW), .CW(CW)) u_mux (
    .op(op), .issue(mem_req),
    .arg_a(arg_a_q), .arg_b(arg_b_q), .arg_c(arg_c_q), .arg_d(arg_d_q),
    .idx(idx_q), .x_val(x_q), .y_val(y_q), .result(result),
    .addr(mem_addr), .we(mem_we), .wdata(mem_wdata)
  );

  // Call arguments: loaded on an accepted start.
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      arg_a_q <= '0;
      arg_b_q <= '0;
      arg_c_q <= '0;
      arg_d_q <= '0;
      trip_q  <= '0;
    end else if (accept) begin
      arg_a_q <= base_a;
      arg_b_q <= base_b;
      arg_c_q <= base_c;
      arg_d_q <= base_d;
      trip_q  <= count_n;
    end
  end

  // Intra-block operand registers on the fast clock.
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      x_q <= '0;
      y_q <= '0;
      d_q <= '0;
    end else begin
      if (cap_x) x_q <= mem_rdata;
      if (cap_y) y_q <= mem_rdata;
      if (cap_d) d_q <= mem_rdata;
    end
  end

  // Inter-block value: moves only on the slow commit enable.
  always_comb begin
    idx_d = idx_q;
    if (accept)          idx_d = '0;
    else if (blk_commit) idx_d = idx_next;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) idx_q <= '0;
    else          idx_q <= idx_d;
  end
endmodule

// File: rtl/lc_checker.sv
module lc_checker #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          done,
  input logic          blk_commit,
  input logic          mem_req,
  input logic          mem_rvalid,
  input logic [CW-1:0] idx_q
);
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req ##1 !mem_req); // R5
  AST_COMMIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    blk_commit |=> !blk_commit); // R7
  AST_COMMIT_ON_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    blk_commit |-> mem_rvalid); // R7
  AST_IDX_SLOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!blk_commit && !start) |=> $stable(idx_q)); // R7
  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(blk_commit) || $past(start))); // R2
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done); // R2
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req); // R3
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (!done && !mem_req && !blk_commit)); // R1
endmodule

bind loop_coproc lc_checker #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done),
  .blk_commit(blk_commit), .mem_req(mem_req), .mem_rvalid(mem_rvalid),
  .idx_q(idx_q)
);

// File: tb/test_loop_coproc.sv
`timescale 1ns/1ps
module test_loop_coproc;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int CW = 8;
  localparam int MS = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] base_a = '0, base_b = '0, base_c = '0, base_d = '0;
  logic [CW-1:0] count_n = '0;
  logic          done, blk_commit, mem_req, mem_we, mem_rvalid;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  loop_coproc #(.AW(AW), .DW(DW), .CW(CW)) i_loop_coproc (
    .clk(clk), .rst_n(rst_n), .start(start),
    .base_a(base_a), .base_b(base_b), .base_c(base_c), .base_d(base_d),
    .count_n(count_n), .done(done), .blk_commit(blk_commit),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  // Memory model: fixed two-cycle response, request log.
  logic [DW-1:0] mem  [MS];
  logic [DW-1:0] refm [MS];
  logic          p1_v, p2_v;
  logic [DW-1:0] p1_d, p2_d;
  int            cyc_ctr = 0;
  int            lg_n = 0;
  int            commit_cnt = 0;
  logic [AW-1:0] lg_addr [64];
  logic          lg_we   [64];
  logic [DW-1:0] lg_wd   [64];
  int            lg_cyc  [64];

  assign mem_rvalid = p2_v;
  assign mem_rdata  = p2_d;

  always @(posedge clk) begin
    cyc_ctr <= cyc_ctr + 1;
    if (!rst_n) begin
      p1_v <= 1'b0; p2_v <= 1'b0; p1_d <= '0; p2_d <= '0;
    end else begin
      p2_v <= p1_v; p2_d <= p1_d;
      p1_v <= mem_req; p1_d <= mem[mem_addr];
      if (mem_req && mem_we) mem[mem_addr] <= mem_wdata;
      if (mem_req && lg_n < 64) begin
        lg_addr[lg_n] <= mem_addr;
        lg_we[lg_n]   <= mem_we;
        lg_wd[lg_n]   <= mem_wdata;
        lg_cyc[lg_n]  <= cyc_ctr;
        lg_n          <= lg_n + 1;
      end
      if (blk_commit) commit_cnt <= commit_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(input int pat, input int n, input logic [AW-1:0] ba,
                     input logic [AW-1:0] bb, input logic [AW-1:0] bc,
                     input logic [AW-1:0] bd);
    logic [AW-1:0] e_addr [64];
    logic          e_we   [64];
    logic [DW-1:0] e_wd   [64];
    logic [DW-1:0] x, y, d, r;
    int cnt, lg_seen, bad;
    @(negedge clk);
    for (int k = 0; k < MS; k++) begin
      mem[k]  = DW'(k * 73 + pat * 29 + 5);
      refm[k] = DW'(k * 73 + pat * 29 + 5);
    end
    for (int i = 0; i < n; i++) begin
      x = refm[AW'(ba + AW'(i))];
      y = refm[AW'(bb + AW'(i))];
      d = refm[AW'(bd + AW'(y))];
      r = d + x + y + x * y;
      e_addr[4*i]   = AW'(ba + AW'(i)); e_we[4*i]   = 1'b0;
      e_addr[4*i+1] = AW'(bb + AW'(i)); e_we[4*i+1] = 1'b0;
      e_addr[4*i+2] = AW'(bd + AW'(y)); e_we[4*i+2] = 1'b0;
      e_addr[4*i+3] = AW'(bc + AW'(x)); e_we[4*i+3] = 1'b1;
      e_wd[4*i+3]   = r;
      refm[AW'(bc + AW'(x))] = r;
    end
    lg_n = 0; commit_cnt = 0;
    base_a = ba; base_b = bb; base_c = bc; base_d = bd; count_n = CW'(n);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt = 1;
    while (!done && cnt < 200) begin
      @(negedge clk);
      cnt++;
    end
    if (n == 0) chk(cnt == 1, "R3 done latency", cnt, 1);
    else        chk(cnt == 12 * n + 1, "R2 done latency", cnt, 12 * n + 1);
    lg_seen = lg_n;
    repeat (5) @(negedge clk);
    chk(done == 1'b1, "R2 done held", done, 1);
    chk(lg_n == lg_seen, "R2 quiet after done", lg_n, lg_seen);
    if (n == 0) chk(lg_n == 0, "R3 no request", lg_n, 0);
    chk(lg_n == 4 * n, "R8 request count", lg_n, 4 * n);
    chk(commit_cnt == n, "R7 commit count", commit_cnt, n);
    for (int k = 0; k < lg_n && k < 4 * n; k++) begin
      chk(lg_addr[k] == e_addr[k], "R4 address order", lg_addr[k], e_addr[k]);
      chk(lg_we[k] == e_we[k], "R5 write enable", lg_we[k], e_we[k]);
      if (e_we[k]) chk(lg_wd[k] == e_wd[k], "R6 store data", lg_wd[k], e_wd[k]);
      if (k > 0) chk(lg_cyc[k] - lg_cyc[k-1] == 3, "R5 request spacing",
                     lg_cyc[k] - lg_cyc[k-1], 3);
    end
    bad = -1;
    for (int k = 0; k < MS; k++) if (bad < 0 && mem[k] != refm[k]) bad = k;
    if (bad < 0) chk(1'b1, "R9 memory image", 0, 0);
    else chk(1'b0, "R9 memory image", mem[bad], refm[bad]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=expired expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R1 reset done", done, 0);
    chk(mem_req == 1'b0, "R1 reset req", mem_req, 0);
    chk(blk_commit == 1'b0, "R1 reset commit", blk_commit, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(done == 1'b0 && mem_req == 1'b0, "R1 idle after reset", done, 0);
    for (int pat = 0; pat < 4; pat++) begin
      for (int n = 0; n < 8; n++) begin
        case (pat)
          0: run(pat, n, 8'd0,   8'd16,  8'd128, 8'd64);
          1: run(pat, n, 8'd40,  8'd20,  8'd200, 8'd100);
          2: run(pat, n, 8'd10,  8'd30,  8'd90,  8'd90);   // C overlaps D
          default: run(pat, n, 8'd250, 8'd252, 8'd3, 8'd254); // wrap
        endcase
      end
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule